// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block turns one active-low board reset pin and five software control bits into the internal reset signals for a global domain and one port domain. Each domain has a full reset and a datapath-only reset. The block also produces the pin-level side effects of those resets: a clock enable that powers down the port, a force-low enable for the port output pins, a high-impedance enable for the processor bus, and an override that turns the general-purpose pins into inputs.

Every reset output asserts as soon as its source rises, with no clock edge needed. Each output releases only after a short synchronizer chain in its own clock domain. A global reset, whether it comes from the pin or from the self-clearing software bit, returns the control bits to their defaults. The defaults leave the datapath resets and the power-down set. Bring-up therefore means clearing power-down, configuring the rest of the chip, and then clearing the datapath resets.

Top module: `rstpd_ctrl`

## Requirements
- R1: When `rst_n_pin` falls, all four reset outputs, `prt_pin_low_o`, `cpu_bus_hiz_o` and `gpio_in_force_o` go to 1 and `prt_clk_en_o` goes to 0 before the next clock edge.
- R2: A reset output falls on the SYNC_STAGES-th (default 2) rising edge of its domain clock after the last of its sources has cleared. Until that edge it stays at 1.
- R3: A global reset, from the pin or from the software bit, sets the global datapath reset, port datapath reset and port power-down bits, and clears the port reset bit. These bits keep their values after the reset ends, until software writes them.
- R4: The software global reset bit clears itself on the clock edge after the one that wrote it. It then reads back as 0, and `glb_rst_o` pulses high.
- R5: Register writes have no effect while `rst_n_pin` is low, and none on the edge at which the software global reset bit is set.
- R6: `prt_rst_o` follows the OR of the global reset and the port reset bit. The port reset bit alone does not raise `glb_rst_o`.
- R7: `glb_dp_rst_o` follows the global reset OR the global datapath bit. `prt_dp_rst_o` follows the OR of the global reset, the global datapath bit, the port reset bit and the port datapath bit.
- R8: `prt_pin_low_o` is 1 whenever `prt_rst_o`, the power-down bit or the port datapath bit is 1, and 0 only when all three are 0.
- R9: `cpu_bus_hiz_o` is 1 exactly while `rst_n_pin` is low. The software global reset does not raise it.
- R10: `gpio_in_force_o` is 1 while the global reset output is asserted, whether the reset came from the pin or from software.
- R11: `prt_clk_en_o` is the inverse of the port power-down bit.
- R12: The register map is as follows. Address 0 holds bit0 = global reset and bit1 = global datapath reset. Address 1 holds bit0 = port reset, bit1 = port datapath reset and bit2 = port power-down. `rd_data` shows the register at `rd_addr` one clock later. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global domain clock, also clocks the control registers |
| port_clk | input | 1 | Port domain clock |
| rst_n_pin | input | 1 | Active-low board reset, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| glb_rst_o | output | 1 | Global reset |
| glb_dp_rst_o | output | 1 | Global datapath reset |
| prt_rst_o | output | 1 | Port reset |
| prt_dp_rst_o | output | 1 | Port datapath reset |
| prt_clk_en_o | output | 1 | Port clock enable (0 = powered down) |
| prt_pin_low_o | output | 1 | Drive port output pins low |
| cpu_bus_hiz_o | output | 1 | Float processor data, ready and interrupt pins |
| gpio_in_force_o | output | 1 | Force general-purpose pins to inputs |

## Verification
Two things can land on the same edge: the forcing effect of the software global reset, and a user write. The bench provokes this by issuing a write to the port register on the clock right after the write that sets the global reset bit. It then reads the port register back and expects the forced defaults rather than the written value. The same collision with the reset pin is provoked by writing while the pin is held low. A sweep over all sixteen combinations of the global datapath bit and the three port bits checks every output against OR terms computed in the bench.

// File: rtl/rstpd_pkg.sv
`timescale 1ns/1ps
package rstpd_pkg;
  // Control bits held by the register file
  typedef struct packed {
    logic grst;  // software global reset, self-clearing
    logic gdp;   // global datapath reset
    logic prst;  // port reset
    logic pdp;   // port datapath reset
    logic pd;    // port power-down
  } ctrl_t;

  // Field positions inside each register word
  localparam int BIT_RST = 0;
  localparam int BIT_DP  = 1;
  localparam int BIT_PD  = 2;
  localparam int MIN_DATA_W = 3;

  // Value taken on any global reset
  localparam ctrl_t CTRL_DEFAULT = '{grst: 1'b0, gdp: 1'b1, prst: 1'b0, pdp: 1'b1, pd: 1'b1};
endpackage

// File: rtl/rstpd_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts with the source, releases after STAGES edges
module rstpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic src_i,
  output logic rst_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or posedge src_i) begin
    if (src_i) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain_q[STAGES-1];

  // R2: release never happens while the source was still high at the edge before
  assert_release_R2: assert property (@(posedge clk_i) disable iff (src_i)
    $fell(rst_o) |-> !$past(src_i));
endmodule

// File: rtl/rstpd_regs.sv
`timescale 1ns/1ps
// Control register file with forced defaults under global reset
module rstpd_regs import rstpd_pkg::*; #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 3,
  parameter logic [ADDR_W-1:0] GLB_ADDR = '0,
  parameter logic [ADDR_W-1:0] PRT_ADDR = 1
) (
  input  logic              clk,
  input  logic              hw_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk or posedge hw_rst_i) begin
    if (hw_rst_i) begin
      ctrl_q <= CTRL_DEFAULT;
    end else if (ctrl_q.grst) begin
      // forced: defaults win, the software bit drops, writes are ignored
      ctrl_q <= CTRL_DEFAULT;
    end else if (wr_en_i) begin
      if (wr_addr_i == GLB_ADDR) begin
        ctrl_q.grst <= wr_data_i[BIT_RST];
        ctrl_q.gdp  <= wr_data_i[BIT_DP];
      end else if (wr_addr_i == PRT_ADDR) begin
        ctrl_q.prst <= wr_data_i[BIT_RST];
        ctrl_q.pdp  <= wr_data_i[BIT_DP];
        ctrl_q.pd   <= wr_data_i[BIT_PD];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == GLB_ADDR) begin
      rd_mux[BIT_RST] = ctrl_q.grst;
      rd_mux[BIT_DP]  = ctrl_q.gdp;
    end else if (rd_addr_i == PRT_ADDR) begin
      rd_mux[BIT_RST] = ctrl_q.prst;
      rd_mux[BIT_DP]  = ctrl_q.pdp;
      rd_mux[BIT_PD]  = ctrl_q.pd;
    end
  end

  always_ff @(posedge clk) rd_data_o <= rd_mux;

  assign ctrl_o = ctrl_q;

  // R4: the software global reset lasts a single cycle
  assert_selfclear_R4: assert property (@(posedge clk) disable iff (hw_rst_i)
    ctrl_q.grst |=> !ctrl_q.grst);
  // R3: after a software global reset the forced bits hold their defaults
  assert_forced_R3: assert property (@(posedge clk) disable iff (hw_rst_i)
    ctrl_q.grst |=> (ctrl_q.gdp && ctrl_q.pdp && ctrl_q.pd && !ctrl_q.prst));
  // R5: a write in the forced cycle leaves power-down set
  assert_nowrite_R5: assert property (@(posedge clk) disable iff (hw_rst_i)
    (ctrl_q.grst && wr_en_i) |=> ctrl_q.pd);
endmodule

// File: rtl/rstpd_ctrl.sv
`timescale 1ns/1ps
// Reset and power-down sequencer: global domain plus one port
module rstpd_ctrl import rstpd_pkg::*; #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = MIN_DATA_W,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] GLB_ADDR = '0,
  parameter logic [ADDR_W-1:0] PRT_ADDR = 1
) (
  input  logic              clk,
  input  logic              port_clk,
  input  logic              rst_n_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              glb_rst_o,
  output logic              glb_dp_rst_o,
  output logic              prt_rst_o,
  output logic              prt_dp_rst_o,
  output logic              prt_clk_en_o,
  output logic              prt_pin_low_o,
  output logic              cpu_bus_hiz_o,
  output logic              gpio_in_force_o
);
  localparam int NUM_DOM_RST = 2;  // full and datapath reset per domain

  logic  hw_rst;
  ctrl_t ctrl;
  logic [NUM_DOM_RST-1:0] glb_src, glb_out, prt_src, prt_out;

  assign hw_rst = ~rst_n_pin;

  rstpd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLB_ADDR(GLB_ADDR), .PRT_ADDR(PRT_ADDR)
  ) u_regs (
    .clk(clk), .hw_rst_i(hw_rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ctrl_o(ctrl)
  );

  // Source hierarchy: each level inherits the one above it
  assign glb_src[0] = hw_rst | ctrl.grst;
  assign glb_src[1] = glb_src[0] | ctrl.gdp;
  assign prt_src[0] = glb_src[0] | ctrl.prst;
  assign prt_src[1] = prt_src[0] | ctrl.gdp | ctrl.pdp;

  for (genvar i = 0; i < NUM_DOM_RST; i++) begin : g_dom
    rstpd_sync #(.STAGES(SYNC_STAGES)) u_glb_sync (
      .clk_i(clk), .src_i(glb_src[i]), .rst_o(glb_out[i]));
    rstpd_sync #(.STAGES(SYNC_STAGES)) u_prt_sync (
      .clk_i(port_clk), .src_i(prt_src[i]), .rst_o(prt_out[i]));
  end

  assign glb_rst_o       = glb_out[0];
  assign glb_dp_rst_o    = glb_out[1];
  assign prt_rst_o       = prt_out[0];
  assign prt_dp_rst_o    = prt_out[1];
  assign prt_clk_en_o    = ~ctrl.pd;
  assign prt_pin_low_o   = prt_out[0] | ctrl.pd | ctrl.pdp;
  assign cpu_bus_hiz_o   = hw_rst;
  assign gpio_in_force_o = glb_out[0];

  // R7: the port datapath reset is never released before the port reset
  assert_nest_R7: assert property (@(posedge port_clk) disable iff (!rst_n_pin)
    prt_rst_o |-> prt_dp_rst_o);
  // R7: same nesting in the global domain
  assert_glbnest_R7: assert property (@(posedge clk) disable iff (!rst_n_pin)
    glb_rst_o |-> glb_dp_rst_o);
  // R8: released pins imply a powered, out-of-reset port
  assert_pins_R8: assert property (@(posedge port_clk) disable iff (!rst_n_pin)
    !prt_pin_low_o |-> (prt_clk_en_o && !prt_rst_o));
endmodule

// File: tb/rstpd_ctrl_tb.sv
`timescale 1ns/1ps
module rstpd_ctrl_tb;
  localparam int AW = 2;
  localparam int DW = 3;

  logic clk = 1'b0;
  logic rst_n_pin = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic glb_rst_o, glb_dp_rst_o, prt_rst_o, prt_dp_rst_o;
  logic prt_clk_en_o, prt_pin_low_o, cpu_bus_hiz_o, gpio_in_force_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rstpd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .port_clk(clk), .rst_n_pin(rst_n_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .glb_rst_o(glb_rst_o), .glb_dp_rst_o(glb_dp_rst_o),
    .prt_rst_o(prt_rst_o), .prt_dp_rst_o(prt_dp_rst_o),
    .prt_clk_en_o(prt_clk_en_o), .prt_pin_low_o(prt_pin_low_o),
    .cpu_bus_hiz_o(cpu_bus_hiz_o), .gpio_in_force_o(gpio_in_force_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all outputs packed: {grst,gdp,prst,pdp,clken,pinlow,hiz,gpio}
  function automatic int outs();
    return {glb_rst_o, glb_dp_rst_o, prt_rst_o, prt_dp_rst_o,
            prt_clk_en_o, prt_pin_low_o, cpu_bus_hiz_o, gpio_in_force_o};
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    // Reset state with pin low
    settle(2);
    check("R1 reset state", outs(), 8'b1111_0111);
    check("R9 hiz under pin", cpu_bus_hiz_o, 1);

    // Release pin: outputs hold for one edge, drop on the second
    rst_n_pin = 1'b1;
    settle(1);
    check("R2 still held after one edge", glb_rst_o, 1);
    check("R2 port still held after one edge", prt_rst_o, 1);
    check("R9 hiz drops with pin", cpu_bus_hiz_o, 0);
    settle(1);
    check("R2 released after two edges", outs(), 8'b0101_0100);
    rd(0, v); check("R3 global reg default", v, 3'b010);
    rd(1, v); check("R3 port reg default", v, 3'b110);

    // Bring-up sequence
    wr(1, 3'b010);
    check("R11 clock enabled once power-down clear", prt_clk_en_o, 1);
    check("R8 pins low while port datapath bit set", prt_pin_low_o, 1);
    wr(0, 3'b000);
    settle(2);
    check("R7 global datapath released", glb_dp_rst_o, 0);
    check("R7 port datapath held by its own bit", prt_dp_rst_o, 1);
    wr(1, 3'b000);
    check("R8 pins released with all three clear", prt_pin_low_o, 0);
    check("R2 port datapath held one write edge later", prt_dp_rst_o, 1);
    settle(1);
    check("R2 port datapath held after one edge", prt_dp_rst_o, 1);
    settle(1);
    check("R2 port datapath released after two edges", prt_dp_rst_o, 0);

    // R12: unmapped address reads zero and takes no write
    wr(2, 3'b111);
    rd(0, v); check("R12 global reg untouched by unmapped write", v, 0);
    rd(1, v); check("R12 port reg untouched by unmapped write", v, 0);
    rd(2, v); check("R12 unmapped address reads zero", v, 0);

    // Sweep global datapath bit and all port bit combinations
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 8; p++) begin
        int prst, pdp, pd, exp;
        prst = p & 1; pdp = (p >> 1) & 1; pd = (p >> 2) & 1;
        wr(0, g << 1);
        wr(1, p);
        settle(3);
        exp = (0 << 7) | (g << 6) | (prst << 5) | ((prst | g | pdp) << 4)
            | ((1 - pd) << 3) | ((prst | pd | pdp) << 2) | (0 << 1) | 0;
        check("R6 R7 R8 R11 sweep outputs", outs(), exp);
        rd(1, v); check("R12 sweep port readback", v, p);
        rd(0, v); check("R12 sweep global readback", v, g << 1);
      end
    end

    // Software global reset colliding with a port write
    wr(0, 3'b000);
    wr(1, 3'b001);
    settle(3);
    check("R6 port reset bit leaves global reset low", glb_rst_o, 0);
    check("R6 port reset bit raises port reset", prt_rst_o, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(0); wr_data = 3'b001;
    @(negedge clk);
    check("R4 software reset asserts global reset", glb_rst_o, 1);
    check("R9 software reset leaves bus driven", cpu_bus_hiz_o, 0);
    check("R10 software reset forces gpio inputs", gpio_in_force_o, 1);
    wr_addr = AW'(1); wr_data = 3'b000;
    @(negedge clk);
    wr_en = 1'b0;
    settle(1);
    check("R4 global reset held before release", glb_rst_o, 1);
    settle(1);
    check("R4 global reset pulse ends", glb_rst_o, 0);
    check("R10 gpio override follows release", gpio_in_force_o, 0);
    rd(0, v); check("R4 software bit self-cleared, R3 datapath set", v, 3'b010);
    rd(1, v); check("R5 write in forced cycle ignored, R3 defaults", v, 3'b110);

    // Pin reset mid-cycle with writes attempted while held
    wr(1, 3'b000);
    wr(0, 3'b000);
    settle(3);
    check("R8 clear before pin test", prt_pin_low_o, 0);
    @(negedge clk);
    rst_n_pin = 1'b0;
    #0.5;
    check("R1 asynchronous assertion", outs(), 8'b1111_0111);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(1); wr_data = 3'b001;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n_pin = 1'b1;
    settle(2);
    rd(1, v); check("R5 write under pin reset ignored", v, 3'b110);
    rd(0, v); check("R3 global reg after pin reset", v, 3'b010);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule